// File: doc/BRIEF.md
# Peripheral I/O Space Access Decoder

This block sits between a CPU bus and the peripheral registers in the top 32 KB of a 24-bit address space (0xFF8000 to 0xFFFFFF). For each request it splits the access into byte lanes and gives each lane a class from a small fixed region map. A lane is a real register, a silent location that reads all ones, a silent location that reads all zeros, or a bus-error location. It then drives one register select per lane, with the sound-chip mirror range folded onto its base registers. It merges the lane read data into one bus and decides whether the whole access ends in a bus error.

Lane i always carries the byte at base address + i, in bits [8i+7:8i] of both the register read bus and the response bus. Lanes beyond the access size read as 0x00. Size codes are 0 = byte (1 lane), 1 = word (2 lanes), 2 = long (4 lanes), and 3 is treated as a byte. A two-state machine (IDLE, RESP) accepts a request in IDLE (transition IDLE to RESP on request valid) and presents the registered response for exactly one cycle in RESP (transition RESP to IDLE always).

The region map is as follows. The sound-chip registers are at 0xFF8800 to 0xFF8803, and 0xFF8804 to 0xFF88FF mirrors them. In the video registers at 0xFF8200 to 0xFF820D, odd bytes are registers and even bytes are bus-error locations. The palette registers are at 0xFF8240 to 0xFF825F and the disk registers at 0xFF8600 to 0xFF860D. The silent all-ones locations are 0xFF820F and 0xFF860F. The silent all-zeros locations are 0xFF8260 to 0xFF8263. Every other location is a bus-error location.

Top module: `pio_space_decoder`

## Requirements
- R1: Only the low 24 bits of the request address are decoded. An access whose 24-bit address is below 0xFF8000 ends in a bus error and asserts no select.
- R2: An access made while the supervisor flag is low ends in a bus error and asserts no select, whatever the region class.
- R3: A bus error is raised only when every lane of the access is a bus-error location: 1 lane for a byte, 2 for a word, 4 for a long. Such an access asserts no select.
- R4: In an access that is only partly made of bus-error lanes, those lanes complete without error, read 0xFF and get no select.
- R5: The all-ones silent class reads 0xFF and the all-zeros silent class reads 0x00. Neither class ever causes a bus error or receives a select, so writes to them are dropped.
- R6: A register select for an address from 0xFF8804 to 0xFF88FF carries the address AND 0xFFF803.
- R7: A word access above 0xFFFFFE or a long access above 0xFFFFFC is rejected. It asserts no select, raises no bus error and reads 0xFFFFFFFF.
- R8: The select on lane i carries the address base + i, so a multi-byte access addresses its registers in ascending byte order from the base.
- R9: Selects are combinational in the accept cycle. The response pulses for exactly one cycle, one cycle after acceptance. A request seen during that response cycle is ignored.
- R10: The write strobe is asserted only with at least one select and only for write requests. Rejected or errored writes assert no select.
- R11: The region map in this brief holds, including the split between even and odd bytes in the video range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | CPU address; the low 24 bits are decoded |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 byte |
| req_write | input | 1 | 1 for a write request |
| req_super | input | 1 | CPU supervisor flag |
| reg_rdata | input | 32 | Register read data, lane aligned |
| reg_sel | output | 4 | Per-lane register select |
| reg_we | output | 1 | Write strobe qualifying the selects |
| reg_addr | output | 96 | Per-lane effective address, 24 bits per lane, lane 0 lowest |
| busy | output | 1 | High in the RESP state |
| resp_valid | output | 1 | Response pulse |
| resp_rdata | output | 32 | Merged, lane-aligned read data |
| resp_berr | output | 1 | Bus error for the response |

## Verification
The bench sweeps every address, every size and both directions across the edges of each region: video, palette with the all-zeros block, disk, the full sound-chip mirror range, the bottom of the window and its top end. Expected values are computed from the region list. A design that counted error lanes per access instead of per byte would raise errors on valid word accesses into the video range, and one that skipped the all-lanes rule would fault on partial hits. A design that dropped the mirror fold would send selects to mirror addresses. Wrong handling at the top of the window would select lanes that wrap past 0xFFFFFF. The bench also sends a request during the busy cycle, which an FSM that did not guard that cycle would accept.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int MAP_AW = 24;

    typedef enum logic [1:0] {
        CLS_BERR    = 2'd0,
        CLS_REG     = 2'd1,
        CLS_VOID_FF = 2'd2,
        CLS_VOID_00 = 2'd3
    } byte_cls_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_state_t;

    localparam logic [MAP_AW-1:0] WIN_BASE  = 24'hFF8000;
    localparam logic [MAP_AW-1:0] WORD_LAST = 24'hFFFFFE;
    localparam logic [MAP_AW-1:0] LONG_LAST = 24'hFFFFFC;
    localparam logic [MAP_AW-1:0] SND_BASE  = 24'hFF8800;
    localparam logic [MAP_AW-1:0] SND_MIR   = 24'hFF8804;
    localparam logic [MAP_AW-1:0] SND_END   = 24'hFF88FF;
    localparam logic [MAP_AW-1:0] SND_MASK  = 24'hFFF803;

    // Class of one byte location in the fixed region map
    function automatic byte_cls_t classify(input logic [MAP_AW-1:0] a);
        byte_cls_t c;
        c = CLS_BERR;
        if (a >= SND_BASE && a <= SND_END)              c = CLS_REG;
        else if (a >= 24'hFF8200 && a <= 24'hFF820D)    c = a[0] ? CLS_REG : CLS_BERR;
        else if (a == 24'hFF820F || a == 24'hFF860F)    c = CLS_VOID_FF;
        else if (a >= 24'hFF8240 && a <= 24'hFF825F)    c = CLS_REG;
        else if (a >= 24'hFF8260 && a <= 24'hFF8263)    c = CLS_VOID_00;
        else if (a >= 24'hFF8600 && a <= 24'hFF860D)    c = CLS_REG;
        return c;
    endfunction

    // Sound-chip mirror fold onto the base registers
    function automatic logic [MAP_AW-1:0] fold(input logic [MAP_AW-1:0] a);
        return (a >= SND_MIR && a <= SND_END) ? (a & SND_MASK) : a;
    endfunction

endpackage

// File: rtl/pio_lane_decode.sv
module pio_lane_decode
    import pio_pkg::*;
#(
    parameter int LANE_IDX = 0,
    parameter int ADDR_W   = MAP_AW,
    parameter int CNT_W    = 3
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  n_lanes,
    output logic              active,
    output byte_cls_t         cls,
    output logic [ADDR_W-1:0] eff_addr
);
    logic [ADDR_W-1:0] lane_addr;

    always_comb begin
        lane_addr = base_addr + ADDR_W'(LANE_IDX);
        active    = (LANE_IDX < int'(n_lanes));
        cls       = classify(lane_addr);
        eff_addr  = fold(lane_addr);
    end
endmodule

// File: rtl/pio_resp_fsm.sv
module pio_resp_fsm
    import pio_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             err_d,
    input  logic [BUS_W-1:0] rdata_d,
    output logic             accept,
    output logic             busy,
    output logic             resp_valid,
    output logic             resp_berr,
    output logic [BUS_W-1:0] resp_rdata
);
    fsm_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept     = (state == ST_IDLE) && req_valid;
        busy       = (state == ST_RESP);
        resp_valid = busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_berr  <= 1'b0;
            resp_rdata <= '0;
        end else if (accept) begin
            resp_berr  <= err_d;
            resp_rdata <= rdata_d;
        end
    end
endmodule

// File: rtl/pio_space_decoder.sv
module pio_space_decoder
    import pio_pkg::*;
#(
    parameter int CPU_AW = 32,
    parameter int ADDR_W = MAP_AW,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int BUS_W = LANES * BYTE_W,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [CPU_AW-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic                    req_write,
    input  logic                    req_super,
    input  logic [BUS_W-1:0]        reg_rdata,
    output logic [LANES-1:0]        reg_sel,
    output logic                    reg_we,
    output logic [LANES*ADDR_W-1:0] reg_addr,
    output logic                    busy,
    output logic                    resp_valid,
    output logic [BUS_W-1:0]        resp_rdata,
    output logic                    resp_berr
);
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  n_lanes;
    logic              in_win, illegal, all_berr, access_err, accept, sel_ok;
    logic [LANES-1:0]  lane_act, lane_berr, lane_reg;
    logic [BUS_W-1:0]  lane_data, rdata_d;

    assign base = req_addr[ADDR_W-1:0];

    always_comb begin
        unique case (acc_size_t'(req_size))
            SZ_WORD: n_lanes = CNT_W'(2);
            SZ_LONG: n_lanes = CNT_W'(4);
            default: n_lanes = CNT_W'(1);
        endcase
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            byte_cls_t cls;
            logic [ADDR_W-1:0] eff;
            pio_lane_decode #(.LANE_IDX(i), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_lane (
                .base_addr (base),
                .n_lanes   (n_lanes),
                .active    (lane_act[i]),
                .cls       (cls),
                .eff_addr  (eff)
            );
            assign lane_berr[i] = lane_act[i] && (cls == CLS_BERR);
            assign lane_reg[i]  = lane_act[i] && (cls == CLS_REG);
            assign reg_addr[i*ADDR_W +: ADDR_W] = eff;

            always_comb begin
                if (!lane_act[i])                     lane_data[i*BYTE_W +: BYTE_W] = '0;
                else if (cls == CLS_REG)              lane_data[i*BYTE_W +: BYTE_W] = reg_rdata[i*BYTE_W +: BYTE_W];
                else if (cls == CLS_VOID_00)          lane_data[i*BYTE_W +: BYTE_W] = '0;
                else                                  lane_data[i*BYTE_W +: BYTE_W] = '1;
            end
        end
    endgenerate

    always_comb begin
        in_win     = (base >= WIN_BASE);
        illegal    = ((acc_size_t'(req_size) == SZ_WORD) && (base > WORD_LAST)) ||
                     ((acc_size_t'(req_size) == SZ_LONG) && (base > LONG_LAST));
        all_berr   = ($countones(lane_berr) == int'(n_lanes));
        access_err = !in_win || !req_super || (!illegal && all_berr);
        sel_ok     = accept && !access_err && !illegal;
        reg_sel    = sel_ok ? lane_reg : '0;
        reg_we     = req_write && (reg_sel != '0);
        rdata_d    = (access_err || illegal) ? '1 : lane_data;
    end

    pio_resp_fsm #(.BUS_W(BUS_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .err_d      (access_err),
        .rdata_d    (rdata_d),
        .accept     (accept),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_berr  (resp_berr),
        .resp_rdata (resp_rdata)
    );
endmodule

// File: rtl/pio_space_decoder_chk.sv
module pio_space_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [1:0]  req_size,
    input logic        req_write,
    input logic        req_super,
    input logic [3:0]  reg_sel,
    input logic        reg_we,
    input logic        busy,
    input logic        resp_valid,
    input logic        resp_berr
);
    AST_OUTSIDE_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_addr[23:0] < 24'hFF8000) |=> resp_berr); // R1
    AST_USER_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_super) |=> resp_berr); // R2
    AST_USER_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !req_super |-> (reg_sel == 4'b0)); // R2
    AST_BERR_HAD_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_berr) |-> ($past(reg_sel) == 4'b0)); // R3
    AST_LONG_TOP_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == 2'd2 && req_addr[23:0] > 24'hFFFFFC) |-> (reg_sel == 4'b0)); // R7
    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> resp_valid); // R9
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R9
    AST_BUSY_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (reg_sel == 4'b0)); // R9
    AST_WE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> req_write); // R10
endmodule

bind pio_space_decoder pio_space_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_write  (req_write),
    .req_super  (req_super),
    .reg_sel    (reg_sel),
    .reg_we     (reg_we),
    .busy       (busy),
    .resp_valid (resp_valid),
    .resp_berr  (resp_berr)
);

// File: tb/pio_space_decoder_bench.sv
module pio_space_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b1;
    logic [31:0] reg_rdata = '0;
    logic [3:0]  reg_sel;
    logic        reg_we;
    logic [95:0] reg_addr;
    logic        busy, resp_valid, resp_berr;
    logic [31:0] resp_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_space_decoder u_pio_space_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_super(req_super),
        .reg_rdata(reg_rdata), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .busy(busy), .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_berr(resp_berr)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // 0 berr, 1 register, 2 reads ones, 3 reads zeros
    function automatic int m_cls(input logic [23:0] a);
        if (a[23:8] == 16'hFF88) return 1;
        if (a[23:4] == 20'hFF820) return (a[3:0] == 4'hF) ? 2 : (a[3:0] <= 4'hD && a[0]) ? 1 : 0;
        if (a[23:4] == 20'hFF860) return (a[3:0] == 4'hF) ? 2 : (a[3:0] <= 4'hD) ? 1 : 0;
        if (a[23:5] == 19'h7FC12) return 1;                 // 0xFF8240..0xFF825F
        if (a[23:2] == 22'h3FE098) return 3;                // 0xFF8260..0xFF8263
        return 0;
    endfunction

    function automatic logic [23:0] m_fold(input logic [23:0] a);
        if (a[23:8] == 16'hFF88 && a[7:0] >= 8'h04) return {a[23:12], 10'b0, a[1:0]} | 24'h000800;
        return a;
    endfunction

    task automatic access(input logic [31:0] addr, input logic [1:0] sz, input bit wr,
                          input bit sup, input string tag);
        logic [23:0] a;
        int nb, nberr;
        bit err, ill;
        logic [3:0] e_sel;
        logic [31:0] e_rd, pat;
        a   = addr[23:0];
        nb  = (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
        pat = 32'hC3A55A3C ^ addr;
        ill = (sz == 2'd1 && a > 24'hFFFFFE) || (sz == 2'd2 && a > 24'hFFFFFC);
        nberr = 0;
        for (int i = 0; i < nb; i++) if (m_cls(a + 24'(i)) == 0) nberr++;
        err = (a < 24'hFF8000) || !sup || (!ill && nberr == nb);
        e_sel = '0;
        e_rd  = '0;
        for (int i = 0; i < nb; i++) begin
            int c;
            c = m_cls(a + 24'(i));
            if (c == 1) begin
                e_sel[i] = !err && !ill;
                e_rd[i*8 +: 8] = pat[i*8 +: 8];
            end else if (c != 3) e_rd[i*8 +: 8] = 8'hFF;
        end
        if (err || ill) e_rd = 32'hFFFFFFFF;

        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_size = sz; req_write = wr;
        req_super = sup; reg_rdata = pat;
        #1;
        chk(tag, $sformatf("select at %h size %0d", addr, sz), {28'b0, reg_sel}, {28'b0, e_sel});
        chk("R10", "write strobe", {31'b0, reg_we}, {31'b0, wr && (e_sel != 0)});
        for (int i = 0; i < 4; i++)
            if (e_sel[i]) chk("R8 R6", $sformatf("lane %0d address", i),
                              {8'b0, reg_addr[i*24 +: 24]}, {8'b0, m_fold(a + 24'(i))});
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "response valid", {31'b0, resp_valid}, 32'd1);
        chk(tag, $sformatf("bus error at %h size %0d", addr, sz), {31'b0, resp_berr}, {31'b0, err});
        chk(tag, $sformatf("read data at %h size %0d", addr, sz), resp_rdata, e_rd);
        @(negedge clk);
    endtask

    task automatic sweep(input logic [31:0] lo, input logic [31:0] hi, input string tag);
        for (logic [32:0] x = {1'b0, lo}; x <= {1'b0, hi}; x++)
            for (int s = 0; s < 3; s++)
                access(x[31:0], 2'(s), x[0] ^ s[0], 1'b1, tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "reset resp_valid", {31'b0, resp_valid}, 32'd0);
        chk("R9", "reset busy", {31'b0, busy}, 32'd0);
        chk("R9", "reset resp_berr", {31'b0, resp_berr}, 32'd0);
        rst_n = 1'b1;

        sweep(32'h00FF81F8, 32'h00FF8212, "R4 R11");
        sweep(32'h00FF823C, 32'h00FF8266, "R5 R11");
        sweep(32'h00FF85FC, 32'h00FF8612, "R5 R11");
        sweep(32'h00FF87FC, 32'h00FF8904, "R6");
        sweep(32'h00FF8000, 32'h00FF8010, "R3");
        sweep(32'h00FFFFF8, 32'h00FFFFFF, "R7");
        sweep(32'h00FF7FFA, 32'h00FF7FFF, "R1");
        access(32'hABFF8801, 2'd0, 1'b1, 1'b1, "R1");
        access(32'h12FF8241, 2'd2, 1'b0, 1'b1, "R1");
        access(32'h00001000, 2'd1, 1'b0, 1'b1, "R1");
        for (int s = 0; s < 3; s++) begin
            access(32'h00FF8800, 2'(s), 1'b1, 1'b0, "R2");
            access(32'h00FF820F, 2'(s), 1'b0, 1'b0, "R2");
        end

        // R9: a request held through the busy cycle is ignored there
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h00FF8800; req_size = 2'd0;
        req_write = 1'b0; req_super = 1'b1;
        @(negedge clk);
        req_addr = 32'h00FF8801;
        #1;
        chk("R9", "select while busy", {28'b0, reg_sel}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "no response for busy-cycle request", {31'b0, resp_valid}, 32'd0);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule